// File: doc/BRIEF.md
# Battery Level Indicator Monitor

This block turns a stream of battery voltage readings, each in millivolts from an external converter, into the state shown to the user. It keeps a bar count from one to four, lowers it as soon as a reading drops under the limit of the current level, and raises it only once a reading clears the higher limit by a safety margin. It also raises a blink flag for a nearly empty cell, repeats a one-cycle low-battery warning pulse at a pace set by the call state, and raises a power-off request that stays high until reset.

Readings arrive on a valid/ready stream. The block never applies back-pressure: ready is always high, and a reading is taken in every cycle where valid is high. A one-second tick input sets the pace of the warning repeats. The talk flag selects the warning limit and repeat period. The wideband-talk flag selects the lower cut-off limit.

Top module: `battery_bar_monitor`

## Requirements
- R1: `smp_ready` is always 1. A reading is taken only in a cycle where `smp_valid` is 1. In any other cycle `smp_mv` has no effect on any output.
- R2: After reset, `bars`, `blink`, `warn` and `pwr_off` are all 0. `bars` = 0 means no reading has been taken yet.
- R3: The first reading after reset sets `bars` from the plain limits, one cycle after the reading: 4 at or above 3870, 3 at or above 3770, 2 at or above 3720, and 1 below 3720 mV.
- R4: Later readings that fall under the limit of the current level move `bars` straight to the plain level of that reading, even if that skips several levels.
- R5: A later reading raises `bars` only to the highest level whose limit plus 30 mV is at or below the reading. Otherwise `bars` stays where it is.
- R6: `blink` is 1 exactly when the last reading taken was at or below 3500 mV. It updates one cycle after the reading.
- R7: With `in_call` = 1, a reading at or below 3500 mV arms the warning if it is idle and pulses `warn` for one cycle on the next cycle. While the warning is armed, `warn` pulses again on every 60th tick, one cycle after that tick.
- R8: With `in_call` = 0 the warning limit is 3460 mV and the repeat period is 180 ticks. Both the limit and the period follow `in_call` at the time of each reading and each tick.
- R9: A reading above the active warning limit disarms the warning and clears its tick count. The next low reading pulses at once again.
- R10: A reading at or below 3100 mV with `wide_talk` = 1, or at or below 3200 mV with `wide_talk` = 0, sets `pwr_off` on the next cycle. `pwr_off` then stays 1 until reset, whatever readings follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Reading present this cycle |
| smp_ready | output | 1 | Always 1; the block takes every reading |
| smp_mv | input | 13 | Battery reading in millivolts |
| in_call | input | 1 | 1 during a call, 0 in standby |
| wide_talk | input | 1 | 1 during a wideband-mode call |
| tick_1s | input | 1 | One-cycle pulse once per second |
| bars | output | 3 | Bar level 1 to 4; 0 before the first reading |
| blink | output | 1 | Bar icon should blink |
| warn | output | 1 | One-cycle low-battery warning pulse |
| pwr_off | output | 1 | Latched power-off request |

## Verification
The hardest state to reach from the ports is a warning repeat in standby. It needs the warning armed by a low reading, then 180 ticks with no reading above the limit in between, and a change of call state that changes both the limit and the period. The stimulus sends ticks on every other cycle and holds readings steady. It switches `in_call` so that a reading between 3460 and 3500 mV disarms the warning, and then lets the full standby period run out. A behavioural model checks every cycle of that run, including the tick one short of the period.

// File: rtl/batt_mon_pkg.sv
package batt_mon_pkg;
  localparam int MV_W = 13;
  typedef logic [2:0] bar_t;
  localparam bar_t BAR_NONE = 3'd0;
endpackage

// File: rtl/bbm_bar_level.sv
module bbm_bar_level
  import batt_mon_pkg::*;
#(
  parameter int MW       = 13,
  parameter int TH2      = 3720,
  parameter int TH3      = 3770,
  parameter int TH4      = 3870,
  parameter int HYS      = 30,
  parameter int BLINK_MV = 3500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [MW-1:0] smp_mv,
  output bar_t          bars,
  output logic          blink
);
  localparam int NTH = 3;
  localparam int EW  = MW + 1;

  function automatic int th_val(input int idx);
    case (idx)
      0:       return TH2;
      1:       return TH3;
      default: return TH4;
    endcase
  endfunction

  logic [NTH-1:0] ge_raw, ge_up;
  logic [EW-1:0]  mv_ext;
  bar_t           raw_lvl, up_lvl, nxt_lvl;

  assign mv_ext = {1'b0, smp_mv};

  for (genvar g = 0; g < NTH; g++) begin : g_cmp
    assign ge_raw[g] = mv_ext >= EW'(th_val(g));
    assign ge_up[g]  = mv_ext >= EW'(th_val(g) + HYS);
  end

  always_comb begin
    raw_lvl = bar_t'(1);
    up_lvl  = bar_t'(1);
    for (int i = 0; i < NTH; i++) begin
      if (ge_raw[i]) raw_lvl = raw_lvl + bar_t'(1);
      if (ge_up[i])  up_lvl  = up_lvl + bar_t'(1);
    end
    if (bars == BAR_NONE || raw_lvl < bars) nxt_lvl = raw_lvl;
    else if (up_lvl > bars)                 nxt_lvl = up_lvl;
    else                                    nxt_lvl = bars;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bars  <= BAR_NONE;
      blink <= 1'b0;
    end else if (smp_valid) begin
      bars  <= nxt_lvl;
      blink <= smp_mv <= MW'(BLINK_MV);
    end
  end

  // R1: outputs move only after a taken reading
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_valid) |-> ($stable(bars) && $stable(blink)));
  // R3: level stays in its legal range
  assert_bar_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bars <= 3'd4);
  // R5: a rise needs the margin above the new level's limit
  assert_rise_margin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bars > $past(bars) && $past(bars) != BAR_NONE) |->
      ({1'b0, $past(smp_mv)} >= EW'(th_val(int'(bars) - 2) + HYS)));
endmodule

// File: rtl/bbm_warn_timer.sv
module bbm_warn_timer #(
  parameter int MW        = 13,
  parameter int CALL_MV   = 3500,
  parameter int IDLE_MV   = 3460,
  parameter int CALL_SECS = 60,
  parameter int IDLE_SECS = 180
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [MW-1:0] smp_mv,
  input  logic          in_call,
  input  logic          tick_1s,
  output logic          warn
);
  localparam int MAXS = (CALL_SECS > IDLE_SECS) ? CALL_SECS : IDLE_SECS;
  localparam int CW   = $clog2(MAXS + 1);

  logic          armed;
  logic [CW-1:0] secs;
  logic [CW-1:0] period;
  logic          is_low, first_hit, keep;

  assign is_low    = smp_mv <= (in_call ? MW'(CALL_MV) : MW'(IDLE_MV));
  assign period    = in_call ? CW'(CALL_SECS) : CW'(IDLE_SECS);
  assign first_hit = smp_valid && is_low && !armed;
  assign keep      = armed && !(smp_valid && !is_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      secs  <= '0;
      warn  <= 1'b0;
    end else begin
      warn <= 1'b0;
      if (first_hit) begin
        armed <= 1'b1;
        secs  <= '0;
        warn  <= 1'b1;
      end else if (!keep) begin
        armed <= 1'b0;
        secs  <= '0;
      end else if (tick_1s) begin
        if (secs + CW'(1) >= period) begin
          secs <= '0;
          warn <= 1'b1;
        end else begin
          secs <= secs + CW'(1);
        end
      end
    end
  end

  // R7: a warning is a single-cycle pulse (periods are at least 2)
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    warn |=> !warn);
  // R7: every pulse follows a reading or a tick
  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> ($past(smp_valid) || $past(tick_1s)));
endmodule

// File: rtl/bbm_cutoff.sv
module bbm_cutoff #(
  parameter int MW      = 13,
  parameter int WIDE_MV = 3100,
  parameter int STD_MV  = 3200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [MW-1:0] smp_mv,
  input  logic          wide_talk,
  output logic          pwr_off
);
  logic [MW-1:0] limit;
  assign limit = wide_talk ? MW'(WIDE_MV) : MW'(STD_MV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           pwr_off <= 1'b0;
    else if (smp_valid && smp_mv <= limit) pwr_off <= 1'b1;
  end

  // R10: request is sticky
  assert_pwr_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |=> pwr_off);
  // R10: request rises only after a taken reading
  assert_pwr_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_off) |-> $past(smp_valid));
endmodule

// File: rtl/battery_bar_monitor.sv
module battery_bar_monitor
  import batt_mon_pkg::*;
#(
  parameter int TH2_MV    = 3720,
  parameter int TH3_MV    = 3770,
  parameter int TH4_MV    = 3870,
  parameter int HYS_MV    = 30,
  parameter int BLINK_MV  = 3500,
  parameter int CALL_MV   = 3500,
  parameter int IDLE_MV   = 3460,
  parameter int CALL_SECS = 60,
  parameter int IDLE_SECS = 180,
  parameter int WIDE_MV   = 3100,
  parameter int STD_MV    = 3200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  output logic            smp_ready,
  input  logic [MV_W-1:0] smp_mv,
  input  logic            in_call,
  input  logic            wide_talk,
  input  logic            tick_1s,
  output logic [2:0]      bars,
  output logic            blink,
  output logic            warn,
  output logic            pwr_off
);
  assign smp_ready = 1'b1;

  bbm_bar_level #(
    .MW(MV_W), .TH2(TH2_MV), .TH3(TH3_MV), .TH4(TH4_MV),
    .HYS(HYS_MV), .BLINK_MV(BLINK_MV)
  ) u_level (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mv(smp_mv),
    .bars(bars), .blink(blink)
  );

  bbm_warn_timer #(
    .MW(MV_W), .CALL_MV(CALL_MV), .IDLE_MV(IDLE_MV),
    .CALL_SECS(CALL_SECS), .IDLE_SECS(IDLE_SECS)
  ) u_warn (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mv(smp_mv),
    .in_call(in_call), .tick_1s(tick_1s), .warn(warn)
  );

  bbm_cutoff #(
    .MW(MV_W), .WIDE_MV(WIDE_MV), .STD_MV(STD_MV)
  ) u_cut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mv(smp_mv),
    .wide_talk(wide_talk), .pwr_off(pwr_off)
  );
endmodule

// File: tb/battery_bar_monitor_bench.sv
module battery_bar_monitor_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        smp_valid = 0;
  logic        smp_ready;
  logic [12:0] smp_mv = 0;
  logic        in_call = 0, wide_talk = 0, tick_1s = 0;
  logic [2:0]  bars;
  logic        blink, warn, pwr_off;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  battery_bar_monitor u_battery_bar_monitor (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_mv(smp_mv), .in_call(in_call), .wide_talk(wide_talk),
    .tick_1s(tick_1s), .bars(bars), .blink(blink), .warn(warn),
    .pwr_off(pwr_off)
  );

  // behavioural reference
  int m_bars, m_cnt;
  bit m_blink, m_warn, m_pwr, m_armed;

  function automatic int plain_level(int v, int margin);
    int l = 1;
    if (v >= 3720 + margin) l++;
    if (v >= 3770 + margin) l++;
    if (v >= 3870 + margin) l++;
    return l;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bars = 0; m_blink = 0; m_warn = 0; m_pwr = 0; m_armed = 0; m_cnt = 0;
    end else begin
      int v, raw, up, wl, per;
      bit low;
      v   = int'(smp_mv);
      wl  = in_call ? 3500 : 3460;
      per = in_call ? 60 : 180;
      low = (v <= wl);
      m_warn = 0;
      if (smp_valid && low && !m_armed) begin
        m_armed = 1; m_cnt = 0; m_warn = 1;
      end else if (smp_valid && !low) begin
        m_armed = 0; m_cnt = 0;
      end else if (m_armed && tick_1s) begin
        m_cnt++;
        if (m_cnt >= per) begin m_cnt = 0; m_warn = 1; end
      end
      if (smp_valid) begin
        raw = plain_level(v, 0);
        up  = plain_level(v, 30);
        if (m_bars == 0 || raw < m_bars) m_bars = raw;
        else if (up > m_bars)            m_bars = up;
        m_blink = (v <= 3500);
        if (v <= (wide_talk ? 3100 : 3200)) m_pwr = 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3/R4/R5 bars model", int'(bars), m_bars);
    chk("R6 blink model", int'(blink), int'(m_blink));
    chk("R7/R8/R9 warn model", int'(warn), int'(m_warn));
    chk("R10 pwr_off model", int'(pwr_off), int'(m_pwr));
    chk("R1 ready", int'(smp_ready), 1);
  end

  task automatic push(input int mv);
    @(negedge clk); smp_valid = 1; smp_mv = 13'(mv);
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1s = 1;
      @(negedge clk); tick_1s = 0;
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk("R2 reset bars", int'(bars), 0);
    chk("R2 reset blink", int'(blink), 0);
    chk("R2 reset warn", int'(warn), 0);
    chk("R2 reset pwr_off", int'(pwr_off), 0);

    // R1: data without valid is ignored
    @(negedge clk); smp_mv = 13'd3000; in_call = 1;
    repeat (4) @(negedge clk);
    chk("R1 ignored bars", int'(bars), 0);
    chk("R1 ignored pwr_off", int'(pwr_off), 0);
    chk("R1 ignored blink", int'(blink), 0);
    in_call = 0;

    push(3900); chk("R3 first reading", int'(bars), 4);
    push(3880); chk("R5 hold at 4", int'(bars), 4);
    push(3860); chk("R4 drop to 3", int'(bars), 3);
    push(3880); chk("R5 no rise without margin", int'(bars), 3);
    push(3900); chk("R5 rise with margin", int'(bars), 4);
    push(3700); chk("R4 drop several levels", int'(bars), 1);
    push(3755); chk("R5 rise to 2", int'(bars), 2);
    push(3790); chk("R5 stay at 2", int'(bars), 2);
    push(3800); chk("R5 rise to 3", int'(bars), 3);

    // call warnings
    in_call = 1;
    push(3500);
    chk("R7 first call warning", int'(warn), 1);
    chk("R6 blink on", int'(blink), 1);
    ticks(59); chk("R7 before period", int'(warn), 0);
    ticks(1);  chk("R7 repeat on 60th tick", int'(warn), 1);
    ticks(30);
    push(3520);
    chk("R9 disarm", int'(warn), 0);
    chk("R6 blink off", int'(blink), 0);
    ticks(60); chk("R9 no repeat when disarmed", int'(warn), 0);
    push(3490); chk("R9 rearm pulses", int'(warn), 1);

    // standby: 3480 is above the standby limit, so it disarms
    in_call = 0;
    push(3480); chk("R8 standby limit disarms", int'(warn), 0);
    push(3460); chk("R8 standby first warning", int'(warn), 1);
    ticks(179); chk("R8 before standby period", int'(warn), 0);
    ticks(1);   chk("R8 repeat on 180th tick", int'(warn), 1);

    // power-off
    wide_talk = 1; in_call = 1;
    push(3150); chk("R10 wide limit not met", int'(pwr_off), 0);
    push(3100); chk("R10 wide limit met", int'(pwr_off), 1);
    push(3900); chk("R10 latched", int'(pwr_off), 1);
    do_reset(); @(negedge clk);
    chk("R2 reset clears pwr_off", int'(pwr_off), 0);
    wide_talk = 0;
    push(3201); chk("R10 std limit not met", int'(pwr_off), 0);
    push(3200); chk("R10 std limit met", int'(pwr_off), 1);
    chk("R3 first after reset", int'(bars), 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule